// File: doc/BRIEF.md
# I2C Controller Byte FIFO Pair

This block holds the two byte queues that sit between the register interface of an I2C master controller and its serial shift engine. Software pushes outgoing bytes into the transmit queue and the engine pops them; the engine pushes received bytes into the receive queue and software reads them. Both queues have the same depth, a parameter that may be 16 or 32 entries.

Each queue has its own threshold register. Each queue also produces level flags. The transmit side reports empty, nearly empty, full and a sticky overrun flag. The receive side reports empty, nearly full and full. A control word carries one flush request bit per queue. Each request bit reads back as set while its flush runs. The flush lasts a fixed number of cycles, and the hardware clears the bit when the flush ends. While a flush runs, every access to that queue is ignored.

Top module: `i2c_fifo_pair`

## Requirements
- R1: After reset both queues are empty, both thresholds read zero, no flush is in progress and the overrun flag is low.
- R2: Bytes written with `tx_wr` leave on `eng_tx_data` in write order, and `eng_tx_pop` advances to the next byte. `tx_full` is high at DEPTH entries and `tx_empty` is high at zero entries.
- R3: Bytes pushed with `eng_rx_push` appear on `rx_rdata` in push order, and `rx_rd` advances to the next byte. `rx_full` and `rx_empty` follow the level. A push into a full receive queue is dropped. While the queue is empty, `rx_rdata` is zero and a read has no effect.
- R4: The transmit and receive thresholds are separate registers. A written value above DEPTH/2-1 is stored as DEPTH/2-1, which is 7 for 16 entries and 15 for 32.
- R5: `tx_nearly_empty` is high exactly when the transmit level is less than or equal to the transmit threshold.
- R6: `rx_nearly_full` is high exactly when the receive level is greater than or equal to the receive threshold.
- R7: A write while the transmit queue is full sets `tx_overrun`. That write leaves the stored bytes and the level unchanged. The flag stays set until a transmit flush.
- R8: A control write with bit 7 set starts a transmit flush, and bit 8 starts a receive flush. The same bit of `ctrl_rdata` reads 1 for exactly FLUSH_CYC cycles and then drops. A request made while that flush is running is ignored.
- R9: A flush empties its queue. While the flush runs, writes, reads, pushes and pops on that queue have no effect.
- R10: The two flushes are independent. A transmit flush leaves the receive queue untouched, and a receive flush leaves the transmit queue untouched.
- R11: A store and a removal on the same queue in the same cycle both take effect, so the level is unchanged. Fullness for overrun and drop decisions is judged on the level held before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 16 | Control word; bit 7 flush transmit, bit 8 flush receive |
| ctrl_rdata | output | 16 | Bits 7 and 8 high while the matching flush runs |
| tx_thr_wr | input | 1 | Transmit threshold write strobe |
| tx_thr_wdata | input | 8 | Transmit threshold value |
| tx_thr_q | output | log2(DEPTH) | Stored transmit threshold |
| rx_thr_wr | input | 1 | Receive threshold write strobe |
| rx_thr_wdata | input | 8 | Receive threshold value |
| rx_thr_q | output | log2(DEPTH) | Stored receive threshold |
| tx_wr | input | 1 | Push a byte into the transmit queue |
| tx_wdata | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Remove the head byte of the receive queue |
| rx_rdata | output | 8 | Receive head byte, zero when empty |
| eng_tx_pop | input | 1 | Engine takes the transmit head byte |
| eng_tx_data | output | 8 | Transmit head byte, zero when empty |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | 8 | Received byte |
| tx_level | output | log2(DEPTH)+1 | Transmit entry count |
| rx_level | output | log2(DEPTH)+1 | Receive entry count |
| tx_empty | output | 1 | Transmit queue empty |
| tx_nearly_empty | output | 1 | Transmit level at or below threshold |
| tx_full | output | 1 | Transmit queue full |
| tx_overrun | output | 1 | Sticky: write attempted while full |
| rx_empty | output | 1 | Receive queue empty |
| rx_nearly_full | output | 1 | Receive level at or above threshold |
| rx_full | output | 1 | Receive queue full |

## Verification
Two functions can land in the same cycle: a software write to a full transmit queue, and an engine pop of that queue. The bench provokes this collision directly and also lets it arise often in a long random phase. The reference model judges fullness on the level before the edge, so in that cycle the pop succeeds and the write is counted as an overrun. The second collision is a flush request that arrives together with accesses to the same queue, and again while that flush is already running. In both cases the model expects the queue to be empty and the flush length to stay unchanged.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
   localparam int unsigned CTRL_W       = 16;
   localparam int unsigned FLUSH_TX_BIT = 7;   // control bit that empties the transmit queue
   localparam int unsigned FLUSH_RX_BIT = 8;   // control bit that empties the receive queue

   function automatic int unsigned thr_limit(input int unsigned depth);
      return depth / 2 - 1;
   endfunction
endpackage

// File: rtl/i2cq_byte_fifo.sv
module i2cq_byte_fifo #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic [CW-1:0] level,
   output logic          full,
   output logic          empty
);
   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("i2cq_byte_fifo: DEPTH must be a power of two");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] cnt;
   logic          push_ok, pop_ok;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign push_ok = push & ~clr & ~full;
   assign pop_ok  = pop & ~clr & ~empty;
   assign level   = cnt;
   assign head    = empty ? '0 : mem[rptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (clr) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         cnt <= cnt + CW'(push_ok) - CW'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= wdata;
   end

   // R7 / R3: a store into a full queue moves nothing
   assert_full_push_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !clr) |=> ($stable(wptr) && $stable(cnt)));
   // R3: a removal from an empty queue moves nothing
   assert_empty_pop_inert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !clr) |=> $stable(rptr));
   // R9: a clear leaves the queue empty
   assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
   // R2: the level never passes the depth
   assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
endmodule

// File: rtl/i2cq_flush_ctl.sv
module i2cq_flush_ctl #(
   parameter int unsigned CYC  = 4,
   localparam int unsigned CNW = $clog2(CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic start,
   output logic busy
);
   generate
      if (CYC < 1) begin : g_bad_cyc
         $error("i2cq_flush_ctl: CYC must be at least 1");
      end
   endgenerate

   logic [CNW-1:0] remain;

   assign start = req & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         remain <= CNW'(CYC - 1);
      end else if (busy) begin
         if (remain == '0) busy <= 1'b0;
         else              remain <= remain - 1'b1;
      end
   end

   // checker-side run length counter
   logic [CNW:0] run_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   // R8: each flush runs exactly CYC cycles
   assert_flush_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_len == (CNW+1)'(CYC)));
   assert_flush_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= (CNW+1)'(CYC));
endmodule

// File: rtl/i2cq_thr_reg.sv
module i2cq_thr_reg #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned IN_W  = 8,
   localparam int unsigned TW   = $clog2(DEPTH),
   localparam int unsigned MAXV = i2cq_pkg::thr_limit(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [IN_W-1:0] din,
   output logic [TW-1:0]   q
);
   generate
      if (IN_W < TW) begin : g_bad_width
         $error("i2cq_thr_reg: IN_W narrower than the threshold field");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= (din > IN_W'(MAXV)) ? TW'(MAXV) : din[TW-1:0];
   end

   // R4: the stored threshold never passes DEPTH/2-1
   assert_thr_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      q <= TW'(MAXV));
   // R4: without a write the threshold holds
   assert_thr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair #(
   parameter int unsigned DEPTH     = 16,
   parameter int unsigned DW        = 8,
   parameter int unsigned FLUSH_CYC = 4,
   parameter int unsigned THR_IN_W  = 8,
   localparam int unsigned TW       = $clog2(DEPTH),
   localparam int unsigned CW       = TW + 1,
   localparam int unsigned CTW      = i2cq_pkg::CTRL_W
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ctrl_wr,
   input  logic [CTW-1:0] ctrl_wdata,
   output logic [CTW-1:0] ctrl_rdata,
   input  logic           tx_thr_wr,
   input  logic [THR_IN_W-1:0] tx_thr_wdata,
   output logic [TW-1:0]  tx_thr_q,
   input  logic           rx_thr_wr,
   input  logic [THR_IN_W-1:0] rx_thr_wdata,
   output logic [TW-1:0]  rx_thr_q,
   input  logic           tx_wr,
   input  logic [DW-1:0]  tx_wdata,
   input  logic           rx_rd,
   output logic [DW-1:0]  rx_rdata,
   input  logic           eng_tx_pop,
   output logic [DW-1:0]  eng_tx_data,
   input  logic           eng_rx_push,
   input  logic [DW-1:0]  eng_rx_data,
   output logic [CW-1:0]  tx_level,
   output logic [CW-1:0]  rx_level,
   output logic           tx_empty,
   output logic           tx_nearly_empty,
   output logic           tx_full,
   output logic           tx_overrun,
   output logic           rx_empty,
   output logic           rx_nearly_full,
   output logic           rx_full
);
   import i2cq_pkg::*;

   generate
      if (DEPTH != 16 && DEPTH != 32) begin : g_bad_depth
         $error("i2c_fifo_pair: DEPTH must be 16 or 32");
      end
      if (CTW <= FLUSH_RX_BIT) begin : g_bad_ctrl
         $error("i2c_fifo_pair: control word too narrow");
      end
   endgenerate

   // index 0 = transmit queue, index 1 = receive queue
   logic [1:0] fl_req, fl_start, fl_busy, q_clr;

   for (genvar g = 0; g < 2; g++) begin : g_flush
      localparam int unsigned BITPOS = (g == 0) ? FLUSH_TX_BIT : FLUSH_RX_BIT;
      assign fl_req[g] = ctrl_wr & ctrl_wdata[BITPOS];
      assign q_clr[g]  = fl_start[g] | fl_busy[g];
      i2cq_flush_ctl #(.CYC(FLUSH_CYC)) u_flush (
         .clk   (clk),
         .rst_n (rst_n),
         .req   (fl_req[g]),
         .start (fl_start[g]),
         .busy  (fl_busy[g])
      );
   end

   logic unused_ctrl_bits;
   assign unused_ctrl_bits = ^ctrl_wdata;

   always_comb begin
      ctrl_rdata               = '0;
      ctrl_rdata[FLUSH_TX_BIT] = fl_busy[0];
      ctrl_rdata[FLUSH_RX_BIT] = fl_busy[1];
   end

   i2cq_thr_reg #(.DEPTH(DEPTH), .IN_W(THR_IN_W)) u_tx_thr (
      .clk (clk), .rst_n (rst_n), .wr (tx_thr_wr), .din (tx_thr_wdata), .q (tx_thr_q)
   );
   i2cq_thr_reg #(.DEPTH(DEPTH), .IN_W(THR_IN_W)) u_rx_thr (
      .clk (clk), .rst_n (rst_n), .wr (rx_thr_wr), .din (rx_thr_wdata), .q (rx_thr_q)
   );

   i2cq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (q_clr[0]),
      .push  (tx_wr),
      .wdata (tx_wdata),
      .pop   (eng_tx_pop),
      .head  (eng_tx_data),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   i2cq_byte_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (q_clr[1]),
      .push  (eng_rx_push),
      .wdata (eng_rx_data),
      .pop   (rx_rd),
      .head  (rx_rdata),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign tx_nearly_empty = (tx_level <= {1'b0, tx_thr_q});
   assign rx_nearly_full  = (rx_level >= {1'b0, rx_thr_q});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tx_overrun <= 1'b0;
      else if (q_clr[0])          tx_overrun <= 1'b0;
      else if (tx_wr && tx_full)  tx_overrun <= 1'b1;
   end

   // R7: overrun is sticky until a transmit flush
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_overrun && !q_clr[0]) |=> tx_overrun);
   // R9: a running flush keeps its queue empty
   assert_tx_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_busy[0] |-> (tx_level == '0));
   assert_rx_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_busy[1] |-> (rx_level == '0));
   // R10: a transmit flush alone never disturbs the receive level
   assert_flush_independent_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_busy[0] && !q_clr[1] && !eng_rx_push && !rx_rd) |=> $stable(rx_level));
   // R8: a request during a flush does not restart it
   assert_no_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_busy[0] |-> !fl_start[0]);
endmodule

// File: tb/tb_i2c_fifo_pair.sv
module tb_i2c_fifo_pair;
   localparam int D   = 16;
   localparam int CYC = 4;
   localparam int TMX = D / 2 - 1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctrl_wr = 0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_rdata;
   logic        tx_thr_wr = 0, rx_thr_wr = 0;
   logic [7:0]  tx_thr_wdata = '0, rx_thr_wdata = '0;
   logic [3:0]  tx_thr_q, rx_thr_q;
   logic        tx_wr = 0, rx_rd = 0, eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0]  tx_wdata = '0, eng_rx_data = '0, rx_rdata, eng_tx_data;
   logic [4:0]  tx_level, rx_level;
   logic        tx_empty, tx_nearly_empty, tx_full, tx_overrun;
   logic        rx_empty, rx_nearly_full, rx_full;

   always #4 clk = ~clk;

   i2c_fifo_pair #(.DEPTH(D), .FLUSH_CYC(CYC)) dut (
      .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
      .ctrl_rdata(ctrl_rdata), .tx_thr_wr(tx_thr_wr), .tx_thr_wdata(tx_thr_wdata),
      .tx_thr_q(tx_thr_q), .rx_thr_wr(rx_thr_wr), .rx_thr_wdata(rx_thr_wdata),
      .rx_thr_q(rx_thr_q), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd),
      .rx_rdata(rx_rdata), .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data), .tx_level(tx_level),
      .rx_level(rx_level), .tx_empty(tx_empty), .tx_nearly_empty(tx_nearly_empty),
      .tx_full(tx_full), .tx_overrun(tx_overrun), .rx_empty(rx_empty),
      .rx_nearly_full(rx_nearly_full), .rx_full(rx_full)
   );

   int nchk = 0, nfail = 0;
   bit done = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   byte unsigned mtq[$], mrq[$];
   int  mtthr = 0, mrthr = 0, mtcnt = 0, mrcnt = 0;
   bit  mtbusy = 0, mrbusy = 0, movr = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mtq.delete(); mrq.delete();
         mtthr = 0; mrthr = 0; mtbusy = 0; mrbusy = 0; movr = 0; mtcnt = 0; mrcnt = 0;
      end else begin
         bit ts, rs, fl, em;
         ts = ctrl_wr && ctrl_wdata[7] && !mtbusy;
         rs = ctrl_wr && ctrl_wdata[8] && !mrbusy;
         if (ts || mtbusy) begin
            mtq.delete(); movr = 0;
         end else begin
            fl = (mtq.size() == D); em = (mtq.size() == 0);
            if (tx_wr && fl) movr = 1;
            if (eng_tx_pop && !em) void'(mtq.pop_front());
            if (tx_wr && !fl) mtq.push_back(tx_wdata);
         end
         if (rs || mrbusy) mrq.delete();
         else begin
            fl = (mrq.size() == D); em = (mrq.size() == 0);
            if (rx_rd && !em) void'(mrq.pop_front());
            if (eng_rx_push && !fl) mrq.push_back(eng_rx_data);
         end
         if (ts) begin mtbusy = 1; mtcnt = CYC - 1; end
         else if (mtbusy) begin if (mtcnt == 0) mtbusy = 0; else mtcnt--; end
         if (rs) begin mrbusy = 1; mrcnt = CYC - 1; end
         else if (mrbusy) begin if (mrcnt == 0) mrbusy = 0; else mrcnt--; end
         if (tx_thr_wr) mtthr = (tx_thr_wdata > TMX) ? TMX : tx_thr_wdata;
         if (rx_thr_wr) mrthr = (rx_thr_wdata > TMX) ? TMX : rx_thr_wdata;
      end
   end

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         chk("R2 tx_level", tx_level, mtq.size());
         chk("R2 tx_empty", tx_empty, mtq.size() == 0);
         chk("R2 tx_full", tx_full, mtq.size() == D);
         chk("R2 eng_tx_data", eng_tx_data, (mtq.size() != 0) ? mtq[0] : 0);
         chk("R5 tx_nearly_empty", tx_nearly_empty, mtq.size() <= mtthr);
         chk("R7 tx_overrun", tx_overrun, movr);
         chk("R3 rx_level", rx_level, mrq.size());
         chk("R3 rx_empty", rx_empty, mrq.size() == 0);
         chk("R3 rx_full", rx_full, mrq.size() == D);
         chk("R3 rx_rdata", rx_rdata, (mrq.size() != 0) ? mrq[0] : 0);
         chk("R6 rx_nearly_full", rx_nearly_full, mrq.size() >= mrthr);
         chk("R4 tx_thr_q", tx_thr_q, mtthr);
         chk("R4 rx_thr_q", rx_thr_q, mrthr);
         chk("R8 ctrl_rdata", ctrl_rdata, (32'(mtbusy) << 7) | (32'(mrbusy) << 8));
      end
   end

   task automatic cyc();
      @(negedge clk); #1;
   endtask

   task automatic idle();
      ctrl_wr = 0; tx_thr_wr = 0; rx_thr_wr = 0; tx_wr = 0; rx_rd = 0;
      eng_tx_pop = 0; eng_rx_push = 0;
   endtask

   initial begin
      int blen;
      repeat (3) cyc();
      chk("R1 tx_empty", tx_empty, 1);
      chk("R1 rx_empty", rx_empty, 1);
      chk("R1 thresholds", {tx_thr_q, rx_thr_q}, 0);
      chk("R1 ctrl_rdata", ctrl_rdata, 0);
      chk("R1 tx_overrun", tx_overrun, 0);
      rst_n = 1;
      cyc();

      // thresholds, one in range and one capped
      tx_thr_wr = 1; tx_thr_wdata = 3; rx_thr_wr = 1; rx_thr_wdata = 20;
      cyc(); idle();
      chk("R4 tx threshold stored", tx_thr_q, 3);
      chk("R4 rx threshold capped", rx_thr_q, TMX);

      // fill transmit queue
      for (int i = 0; i < D; i++) begin
         tx_wr = 1; tx_wdata = 8'(8'h40 + i); cyc();
         if (i == 2) chk("R5 nearly empty at thr", tx_nearly_empty, 1);
         if (i == 3) chk("R5 nearly empty above thr", tx_nearly_empty, 0);
      end
      idle();
      chk("R2 full after DEPTH writes", tx_full, 1);
      tx_wr = 1; tx_wdata = 8'hEE; cyc(); idle();
      chk("R7 overrun set", tx_overrun, 1);
      chk("R7 level kept", tx_level, D);
      chk("R7 head kept", eng_tx_data, 8'h40);

      // drain in order
      for (int i = 0; i < D; i++) begin
         chk("R2 order", eng_tx_data, 8'h40 + i);
         eng_tx_pop = 1; cyc(); idle();
      end
      chk("R7 overrun sticky", tx_overrun, 1);

      // full transmit queue: write and pop in one cycle
      for (int i = 0; i < D; i++) begin tx_wr = 1; tx_wdata = 8'(i); cyc(); end
      tx_wr = 1; eng_tx_pop = 1; tx_wdata = 8'h99; cyc(); idle();
      chk("R11 pop with full write", tx_level, D - 1);

      // receive path
      for (int i = 0; i < D; i++) begin
         eng_rx_push = 1; eng_rx_data = 8'(8'h80 + i); cyc();
         if (i == 5) chk("R6 below thr", rx_nearly_full, 0);
         if (i == 6) chk("R6 at thr", rx_nearly_full, 1);
      end
      eng_rx_data = 8'hFF; cyc(); idle();
      chk("R3 push to full dropped", rx_level, D);
      for (int i = 0; i < D; i++) begin
         chk("R3 order", rx_rdata, 8'h80 + i);
         rx_rd = 1; cyc(); idle();
      end
      rx_rd = 1; cyc(); idle();
      chk("R3 empty read zero", rx_rdata, 0);
      chk("R3 empty read level", rx_level, 0);
      for (int i = 0; i < 3; i++) begin eng_rx_push = 1; eng_rx_data = 8'(i); cyc(); end
      eng_rx_push = 1; rx_rd = 1; cyc(); idle();
      chk("R11 push with read", rx_level, 3);

      // transmit flush with accesses and a repeated request
      ctrl_wr = 1; ctrl_wdata = 16'h0080; cyc(); ctrl_wr = 0;
      blen = 0;
      tx_wr = 1; eng_tx_pop = 1;
      while (ctrl_rdata[7] && blen < 20) begin
         blen++;
         ctrl_wr = (blen == 2);
         cyc();
      end
      idle();
      chk("R8 flush length", blen, CYC);
      chk("R9 tx empty after flush", tx_level, 0);
      chk("R7 overrun cleared by flush", tx_overrun, 0);
      chk("R10 rx untouched", rx_level, 3);

      // receive flush
      for (int i = 0; i < 2; i++) begin tx_wr = 1; tx_wdata = 8'(i); cyc(); end
      idle();
      ctrl_wr = 1; ctrl_wdata = 16'h0100; cyc(); idle();
      eng_rx_push = 1; cyc(); idle();
      repeat (CYC) cyc();
      chk("R9 rx empty after flush", rx_level, 0);
      chk("R10 tx untouched", tx_level, 2);

      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         tx_wr = ($urandom_range(0, 9) < 5); tx_wdata = 8'($urandom);
         eng_tx_pop = ($urandom_range(0, 9) < 4);
         eng_rx_push = ($urandom_range(0, 9) < 5); eng_rx_data = 8'($urandom);
         rx_rd = ($urandom_range(0, 9) < 4);
         ctrl_wr = ($urandom_range(0, 59) == 0); ctrl_wdata = 16'($urandom) & 16'h0180;
         tx_thr_wr = ($urandom_range(0, 99) == 0); tx_thr_wdata = 8'($urandom_range(0, 20));
         rx_thr_wr = ($urandom_range(0, 99) == 0); rx_thr_wdata = 8'($urandom_range(0, 20));
         cyc();
      end
      idle();
      cyc();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         nchk++; nfail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
         $finish;
      end
   end
endmodule